// File: doc/BRIEF.md
# Conflict-Only Instruction Cache

This block sits beside the program sequencer of a processor whose program memory carries both instruction fetches and data operands. When a fetch and a program-memory data access land in the same cycle, the data access keeps the shared bus. The cache then supplies the instruction, so the core still takes an instruction and two operands in one cycle. Fetches that meet no data access go straight to memory. The cache neither answers them nor stores them, so its few entries are spent only on the instructions inside tight loops that actually collide, such as filter multiply-accumulate kernels and FFT butterflies.

The storage holds 32 words of 48 bits. It is arranged as 16 sets of two ways, indexed by the low four address bits and tagged by the remaining address bits. A conflicting fetch that misses raises a one-cycle stall. During that cycle the bus is free, so the block takes the instruction word from memory, hands it on in the next cycle and keeps a copy. A flush input empties the cache in one cycle. A freeze input lets the cache keep serving hits while blocking new allocations.

Top module: `conflict_icache`

## Requirements
- R1: The cache holds up to 32 instructions at once: 16 sets selected by `fetch_addr[3:0]`, two ways per set, each way holding a 48-bit word and the address bits above the index as its tag.
- R2: A fetch with `pm_conflict` low is never looked up or stored. In the next cycle `hit`=0, `stall`=0, and `instr` equals the `mem_word` driven in the fetch cycle. A later conflicting fetch of the same address still misses.
- R3: A conflicting fetch whose address is resident gives, in the next cycle, `hit`=1, `stall`=0, and `instr` equal to the stored word, whatever `mem_word` carries in the fetch cycle.
- R4: A conflicting fetch that misses gives `stall`=1 and `hit`=0 in the next cycle, which is the stall cycle. The `mem_word` presented in the stall cycle appears on `instr` in the following cycle, with `hit`=0 and `stall`=0, and `stall` never stays high for two cycles.
- R5: Requests presented during the stall cycle are ignored. They produce no output and allocate nothing.
- R6: A fill goes into way 0 if that way is invalid, otherwise into way 1 if that way is invalid. If both are valid, it goes into the way least recently used. The least-recently-used record is updated on every hit and on every fill.
- R7: `flush` invalidates every entry at the end of the cycle in which it is high. A fetch in that same cycle is looked up against the contents from before the flush, and a fill whose stall cycle has `flush` high is discarded.
- R8: `freeze` high during a stall cycle still delivers the word but does not store it. `freeze` has no effect on hits or on non-conflicting fetches.
- R9: After the synchronous reset `rst`, `hit` and `stall` are 0 and no entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | An instruction fetch is requested this cycle |
| fetch_addr | input | 24 | Fetch address |
| pm_conflict | input | 1 | A program-memory data access uses the bus this cycle |
| mem_word | input | 48 | Instruction word from program memory |
| flush | input | 1 | Invalidate all entries |
| freeze | input | 1 | Block new allocations |
| hit | output | 1 | The instruction came from the cache |
| instr | output | 48 | Instruction for the fetch issued in the previous active cycle |
| stall | output | 1 | Fetch stalled for one cycle to fill a miss |

## Verification
The bench mixes fetches without conflicts, conflicting misses and conflicting hits over a small address pool with three tags per set. This forces the cache to fill, hit, age and evict in the same runs. During conflicting fetches the bench drives random garbage on `mem_word`, so a hit that wrongly took the memory word shows up as a data mismatch rather than hiding behind a correct value. Directed sequences cover cases a random run seldom reaches with certainty: one set worked through invalid-way fill, least-recently-used eviction and re-hit; all 32 entries filled and then hit; a flush or freeze landing in the lookup cycle or in the stall cycle; and a request driven during a stall.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int NWAYS = 2;
  typedef enum logic {ST_LOOK, ST_FILL} cic_state_e;
endpackage

// File: rtl/cic_way_ram.sv
module cic_way_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 48,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // simple dual-port: synchronous write, registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cic_tag_store.sv
module cic_tag_store #(
  parameter int SETS  = 16,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] look_idx,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_hit,
  output logic             look_way,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_way,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             freeze,
  input  logic             flush,
  output logic             alloc_way
);
  import cic_pkg::*;

  logic [NWAYS-1:0][SETS-1:0] valid_q;
  logic [TAG_W-1:0]           tag_q [NWAYS][SETS];
  logic [SETS-1:0]            victim_q;   // per set: way to replace next
  logic [NWAYS-1:0]           way_hit;
  logic                       alloc_go;

  for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
    assign way_hit[w] = valid_q[w][look_idx] && (tag_q[w][look_idx] == look_tag);
  end

  assign look_hit = |way_hit;
  assign look_way = way_hit[1];

  always_comb begin
    if (!valid_q[0][alloc_idx])      alloc_way = 1'b0;
    else if (!valid_q[1][alloc_idx]) alloc_way = 1'b1;
    else                             alloc_way = victim_q[alloc_idx];
  end

  assign alloc_go = alloc_en && !freeze && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      victim_q <= '0;
    end else begin
      if (touch_en) victim_q[touch_idx] <= ~touch_way;
      if (alloc_go) begin
        valid_q[alloc_way][alloc_idx] <= 1'b1;
        victim_q[alloc_idx]           <= ~alloc_way;
      end
      if (flush) valid_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_go) tag_q[alloc_way][alloc_idx] <= alloc_tag;
  end

  // R7: one cycle after flush no entry survives
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0));

  // R8: a frozen fill leaves the valid bits untouched
  p_freeze_noalloc_r8: assert property (@(posedge clk) disable iff (rst)
    (alloc_en && freeze && !flush) |=> $stable(valid_q));

  // R6: an address never lives in both ways of a set
  p_single_way_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_hit));
endmodule

// File: rtl/conflict_icache.sv
module conflict_icache #(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 48,
  parameter int SETS   = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              pm_conflict,
  input  logic [WORD_W-1:0] mem_word,
  input  logic              flush,
  input  logic              freeze,
  output logic              hit,
  output logic [WORD_W-1:0] instr,
  output logic              stall
);
  import cic_pkg::*;

  cic_state_e        state_q;
  logic [ADDR_W-1:0] pend_q;
  logic              hit_q, stall_q, use_cache_q, way_q;
  logic [WORD_W-1:0] memword_q;
  logic [WORD_W-1:0] way_rdata [NWAYS];

  logic look_hit, look_way, alloc_way;
  logic in_look, in_fill, req, conf_hit, conf_miss, fill_go;

  assign in_look   = (state_q == ST_LOOK);
  assign in_fill   = (state_q == ST_FILL);
  assign req       = in_look && fetch_valid;
  assign conf_hit  = req && pm_conflict && look_hit;
  assign conf_miss = req && pm_conflict && !look_hit;
  assign fill_go   = in_fill && !freeze && !flush;

  cic_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .look_idx  (fetch_addr[IDX_W-1:0]),
    .look_tag  (fetch_addr[ADDR_W-1:IDX_W]),
    .look_hit  (look_hit),
    .look_way  (look_way),
    .touch_en  (conf_hit),
    .touch_idx (fetch_addr[IDX_W-1:0]),
    .touch_way (look_way),
    .alloc_en  (in_fill),
    .alloc_idx (pend_q[IDX_W-1:0]),
    .alloc_tag (pend_q[ADDR_W-1:IDX_W]),
    .freeze    (freeze),
    .flush     (flush),
    .alloc_way (alloc_way)
  );

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    cic_way_ram #(.DEPTH(SETS), .WIDTH(WORD_W)) u_ram (
      .clk   (clk),
      .we    (fill_go && (alloc_way == 1'(w))),
      .waddr (pend_q[IDX_W-1:0]),
      .wdata (mem_word),
      .raddr (fetch_addr[IDX_W-1:0]),
      .rdata (way_rdata[w])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_LOOK;
      pend_q      <= '0;
      hit_q       <= 1'b0;
      stall_q     <= 1'b0;
      use_cache_q <= 1'b0;
      way_q       <= 1'b0;
      memword_q   <= '0;
    end else begin
      case (state_q)
        ST_LOOK: begin
          hit_q       <= conf_hit;
          stall_q     <= conf_miss;
          use_cache_q <= conf_hit;
          way_q       <= look_way;
          if (req && !pm_conflict) memword_q <= mem_word;
          if (conf_miss) begin
            state_q <= ST_FILL;
            pend_q  <= fetch_addr;
          end
        end
        default: begin
          hit_q       <= 1'b0;
          stall_q     <= 1'b0;
          use_cache_q <= 1'b0;
          memword_q   <= mem_word;
          state_q     <= ST_LOOK;
        end
      endcase
    end
  end

  assign hit   = hit_q;
  assign stall = stall_q;
  assign instr = use_cache_q ? way_rdata[way_q] : memword_q;

  // R4: hit and stall are never raised together
  p_hit_stall_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(hit && stall));

  // R4: a stall lasts exactly one cycle
  p_stall_single_r4: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

  // R4: the word seen during the stall cycle is delivered next
  p_stall_deliver_r4: assert property (@(posedge clk) disable iff (rst)
    stall |=> (instr == $past(mem_word)));

  // R2: a fetch without a conflict never hits or stalls
  p_noconf_bypass_r2: assert property (@(posedge clk) disable iff (rst)
    (in_look && fetch_valid && !pm_conflict) |=> (!hit && !stall));

  // R5: a request during the stall cycle produces no stall or hit
  p_ignore_in_stall_r5: assert property (@(posedge clk) disable iff (rst)
    in_fill |=> (!hit && !stall));
endmodule

// File: tb/conflict_icache_tb.sv
module conflict_icache_tb;
  localparam int AW = 24;
  localparam int WW = 48;

  logic          clk = 1'b0;
  logic          rst;
  logic          fetch_valid;
  logic [AW-1:0] fetch_addr;
  logic          pm_conflict;
  logic [WW-1:0] mem_word;
  logic          flush;
  logic          freeze;
  logic          hit;
  logic [WW-1:0] instr;
  logic          stall;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  bit            mv   [2][16];
  logic [AW-5:0] mt   [2][16];
  bit            mvic [16];

  always #5 clk = ~clk;

  conflict_icache u_dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .pm_conflict(pm_conflict), .mem_word(mem_word), .flush(flush),
    .freeze(freeze), .hit(hit), .instr(instr), .stall(stall)
  );

  function automatic logic [WW-1:0] fw(input logic [AW-1:0] a);
    return {a ^ 24'h5A3C71, a * 24'd40503 + 24'h001234};
  endfunction

  function automatic logic [WW-1:0] rnd48();
    return {$urandom(), $urandom()} >> 16;
  endfunction

  task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 16; s++) begin
      mv[0][s] = 0; mv[1][s] = 0; mvic[s] = 0;
    end
  endtask

  task automatic drive_idle();
    fetch_valid = 0; pm_conflict = 0; flush = 0; freeze = 0;
    fetch_addr = '0; mem_word = '0;
  endtask

  task automatic idle_cycle();
    drive_idle();
    @(posedge clk); @(negedge clk);
  endtask

  // One fetch, called at a negedge. Returns after the result has been checked.
  task automatic fetch(input logic [AW-1:0] a, input bit conf, input bit fl,
                       input bit fz_look, input bit fz_fill, input bit fl_fill,
                       input bit junk, input string tag);
    int idx = int'(a[3:0]);
    logic [AW-5:0] tg = a[AW-1:4];
    bit eh = 0;
    bit ew = 0;
    for (int w = 0; w < 2; w++)
      if (mv[w][idx] && mt[w][idx] == tg) begin eh = 1; ew = w[0]; end
    fetch_valid = 1; fetch_addr = a; pm_conflict = conf; flush = fl; freeze = fz_look;
    mem_word = conf ? rnd48() : fw(a);
    @(posedge clk);
    if (conf && eh) mvic[idx] = ~ew;
    if (fl) for (int s = 0; s < 16; s++) begin mv[0][s] = 0; mv[1][s] = 0; end
    @(negedge clk);
    if (conf && !eh) begin
      chk({tag, " R4 stall"}, stall, 1);
      chk({tag, " R4 hit"},   hit,   0);
      mem_word = fw(a); freeze = fz_fill; flush = fl_fill;
      fetch_valid = junk; pm_conflict = junk;
      fetch_addr = junk ? AW'($urandom_range(0, 255)) : '0;
      @(posedge clk);
      if (!fz_fill && !fl_fill) begin
        bit vw = !mv[0][idx] ? 1'b0 : (!mv[1][idx] ? 1'b1 : mvic[idx]);
        mv[vw][idx] = 1; mt[vw][idx] = tg; mvic[idx] = ~vw;
      end
      if (fl_fill) for (int s = 0; s < 16; s++) begin mv[0][s] = 0; mv[1][s] = 0; end
      @(negedge clk);
      chk({tag, " R4 instr"}, instr, fw(a));
      chk({tag, " R5 stall"}, stall, 0);
      chk({tag, " R5 hit"},   hit,   0);
    end else begin
      chk({tag, conf ? " R3 hit" : " R2 hit"}, hit, conf);
      chk({tag, " stall"}, stall, 0);
      chk({tag, conf ? " R3 instr" : " R2 instr"}, instr, fw(a));
    end
    drive_idle();
  endtask

  task automatic expect_miss(input logic [AW-1:0] a, input string tag);
    // conflicting fetch that must miss; the checks inside name R4
    int idx = int'(a[3:0]);
    bit eh = (mv[0][idx] && mt[0][idx] == a[AW-1:4]) || (mv[1][idx] && mt[1][idx] == a[AW-1:4]);
    chk({tag, " model-miss"}, eh, 0);
    fetch(a, 1, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin : watchdog
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    drive_idle();
    rst = 1;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R9 hit after reset",   hit,   0);
    chk("R9 stall after reset", stall, 0);
    expect_miss(24'h000123, "R9 empty");

    // R2: bypass does not allocate; then R4 fill, R3 hit
    fetch(24'h000410, 0, 0, 0, 0, 0, 0, "R2 bypass");
    expect_miss(24'h000410, "R2 not stored");
    fetch(24'h000410, 1, 0, 0, 0, 0, 0, "R3 after fill");
    fetch(24'h000410, 0, 0, 1, 0, 0, 0, "R8 freeze on bypass");

    // R6: allocation order and eviction in set 5
    fetch(24'h000015, 1, 0, 0, 0, 0, 0, "R6 A");
    fetch(24'h000025, 1, 0, 0, 0, 0, 0, "R6 B");
    fetch(24'h000015, 1, 0, 0, 0, 0, 0, "R6 A hit");
    fetch(24'h000035, 1, 0, 0, 0, 0, 0, "R6 C evicts B");
    fetch(24'h000015, 1, 0, 1, 0, 0, 0, "R6 A kept");
    fetch(24'h000035, 1, 0, 0, 0, 0, 0, "R6 C kept");
    expect_miss(24'h000025, "R6 B evicted");

    // R5: junk request during a stall must not allocate
    fetch(24'h000077, 1, 0, 0, 0, 0, 1, "R5 junk");
    for (int k = 0; k < 4; k++) fetch(24'h000088, 1, 0, 0, 0, 0, 1, "R5 junk2");

    // R8: frozen fill delivers but does not store
    fetch(24'h000A0C, 1, 0, 0, 1, 0, 0, "R8 frozen fill");
    expect_miss(24'h000A0C, "R8 not stored");

    // R7: flush in lookup cycle sees old contents, then empties
    fetch(24'h000A0C, 1, 1, 0, 0, 0, 0, "R7 pre-flush hit");
    expect_miss(24'h000A0C, "R7 flushed");
    fetch(24'h000B0D, 1, 0, 0, 0, 1, 0, "R7 flush in fill");
    expect_miss(24'h000B0D, "R7 fill discarded");
    fetch(24'h000000, 0, 1, 0, 0, 0, 0, "R7 flush");

    // R1: 32 distinct entries, then all resident
    for (int s = 0; s < 16; s++) begin
      fetch(AW'(32'h100 + s), 1, 0, 0, 0, 0, 0, "R1 fill");
      fetch(AW'(32'h200 + s), 1, 0, 0, 0, 0, 0, "R1 fill");
    end
    for (int s = 0; s < 16; s++) begin
      fetch(AW'(32'h100 + s), 1, 0, 0, 0, 0, 0, "R1 resident");
      fetch(AW'(32'h200 + s), 1, 0, 0, 0, 0, 0, "R1 resident");
    end

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a = {AW'($urandom_range(0, 2)) << 4} | AW'($urandom_range(0, 15));
      bit conf = ($urandom_range(0, 99) < 65);
      bit fl   = ($urandom_range(0, 99) < 2);
      bit fzl  = ($urandom_range(0, 99) < 10);
      bit fzf  = ($urandom_range(0, 99) < 10);
      bit flf  = ($urandom_range(0, 99) < 2);
      bit jk   = ($urandom_range(0, 99) < 30);
      if ($urandom_range(0, 99) < 10) idle_cycle();
      fetch(a, conf, fl, fzl, fzf, flf, jk, "rand");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule